// File: doc/BRIEF.md
# Memory-Mapped Down-Counting Timer Bank

This block holds a configurable number of down-counting timer channels behind an APB slave port. Each channel has a reload register, a live count that software can read, and a three-bit control register. A channel can run in one of two reload modes. It raises an interrupt when its count passes through zero, and software can mask that interrupt. A pending interrupt is acknowledged by reading, not by writing. A shared register group reports all channels at once, acknowledges all of them with one read, and returns a fixed identification word. Because the counter falls, software gets a rising timestamp by inverting the value it reads.

Channel `n` occupies byte addresses `n*0x14` to `n*0x14+0x10`. The shared group sits at `0xA0` to `0xAC`, so at most eight channels fit. Each channel runs a two-state engine. In `CH_HALT` the count is frozen. The transition *arm* (enable seen as 1) copies the reload register into the count and enters `CH_RUN`. In `CH_RUN` the count falls by one each cycle. The transition *wrap* (count is zero) reloads the count and marks a terminal event. The transition *stop* (enable seen as 0) returns to `CH_HALT` and leaves the count untouched.

Top module: `apb_tick_timer`

## Requirements
- R1: After reset every readable register returns 0 and every interrupt output is low.
- R2: Register layout, relative to the channel base `n*0x14`: reload value at 0x00 (read/write), live count at 0x04 (read only), control at 0x08, acknowledge at 0x0C, masked status at 0x10 (bit 0). Control bit 0 enables the channel. The cycle after the enable bit is seen as 1 while halted, the count equals the reload value, and it then falls by one per cycle.
- R3: When control bit 1 is 1 (periodic), a count of zero is followed by the reload value, and that cycle sets the channel's raw pending bit.
- R4: When control bit 1 is 0 (free-running), a count of zero is followed by all ones, and that cycle sets the raw pending bit.
- R5: Writing 0 to control bit 0 halts the count: the live count holds its value for as long as the channel stays disabled.
- R6: When control bit 2 (mask) is 1, the channel's interrupt output and its masked status stay low, but its raw pending bit still sets on a terminal event.
- R7: A read of a channel's acknowledge register at 0x0C returns 0, clears only that channel's pending bit, and changes nothing else.
- R8: A read of 0xA4 returns 0 and clears the pending bits of all channels.
- R9: A terminal event in the same cycle as an acknowledge read wins, so the pending bit stays set.
- R10: 0xA0 returns the masked status of channel `n` in bit `n`, 0xA8 returns the raw status in bit `n`, and 0xAC returns the `VERSION_ID` parameter.
- R11: Unmapped addresses read as 0, and writes to them or to read-only registers have no effect. `pready` is always 1 and `pslverr` is always 0.
- R12: `tmr_irq[n]` is raw pending AND NOT mask for channel `n`, and `tmr_irq_any` is the OR of all `tmr_irq` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and timer clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, valid in access phase |
| pready | output | 1 | Always 1 (no wait states) |
| pslverr | output | 1 | Always 0 (no error response) |
| tmr_irq | output | NUM_CH | Per-channel interrupt |
| tmr_irq_any | output | 1 | OR of all channel interrupts |

## Verification
Two functions can land in the same cycle: a channel's wrap from zero, which sets its pending bit, and an acknowledge read, which clears it. The bench follows the channel's live count in its reference model. It starts an acknowledge read exactly two cycles before the count reaches zero, so the access-phase edge and the wrap edge are the same edge. Afterwards it checks that the interrupt is still high. Both the per-channel and the global acknowledge paths are also exercised at quiet moments, and there each must clear the pending bit.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned OFF_LOAD  = 'h00;
    localparam int unsigned OFF_CUR   = 'h04;
    localparam int unsigned OFF_CTRL  = 'h08;
    localparam int unsigned OFF_ACK   = 'h0C;
    localparam int unsigned OFF_STAT  = 'h10;
    localparam int unsigned CH_STRIDE = 'h14;

    localparam int unsigned G_STAT    = 'hA0;
    localparam int unsigned G_ACK     = 'hA4;
    localparam int unsigned G_RAW     = 'hA8;
    localparam int unsigned G_VER     = 'hAC;

    localparam int unsigned CTRL_W    = 3;
    localparam int unsigned BIT_EN    = 0;
    localparam int unsigned BIT_PER   = 1;
    localparam int unsigned BIT_MASK  = 2;

    typedef enum logic [3:0] {
        RK_NONE,
        RK_LOAD,
        RK_CUR,
        RK_CTRL,
        RK_ACK,
        RK_STAT,
        RK_GSTAT,
        RK_GACK,
        RK_GRAW,
        RK_GVER
    } reg_kind_e;

    typedef enum logic [0:0] {
        CH_HALT,
        CH_RUN
    } ch_state_e;

endpackage

// File: rtl/tmr_addr_decode.sv
module tmr_addr_decode
    import tmr_pkg::*;
#(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [NUM_CH-1:0] ch_sel_o,
    output reg_kind_e         kind_o
);

    localparam logic [ADDR_W-1:0] A_LOAD  = ADDR_W'(OFF_LOAD);
    localparam logic [ADDR_W-1:0] A_CUR   = ADDR_W'(OFF_CUR);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_ACK   = ADDR_W'(OFF_ACK);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] A_GSTAT = ADDR_W'(G_STAT);
    localparam logic [ADDR_W-1:0] A_GACK  = ADDR_W'(G_ACK);
    localparam logic [ADDR_W-1:0] A_GRAW  = ADDR_W'(G_RAW);
    localparam logic [ADDR_W-1:0] A_GVER  = ADDR_W'(G_VER);

    logic [NUM_CH-1:0] in_rng;
    logic [ADDR_W-1:0] off_v [NUM_CH];
    logic [ADDR_W-1:0] off;
    logic              hit;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_rng
        localparam int unsigned BASE = g * CH_STRIDE;
        assign in_rng[g] = (int'(addr_i) >= BASE) && (int'(addr_i) < BASE + CH_STRIDE);
        assign off_v[g]  = addr_i - ADDR_W'(BASE);
    end

    always_comb begin
        ch_sel_o = '0;
        off      = '0;
        hit      = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (in_rng[i]) begin
                ch_sel_o[i] = 1'b1;
                off         = off_v[i];
                hit         = 1'b1;
            end
        end
    end

    always_comb begin
        kind_o = RK_NONE;
        if (hit) begin
            case (off)
                A_LOAD:  kind_o = RK_LOAD;
                A_CUR:   kind_o = RK_CUR;
                A_CTRL:  kind_o = RK_CTRL;
                A_ACK:   kind_o = RK_ACK;
                A_STAT:  kind_o = RK_STAT;
                default: kind_o = RK_NONE;
            endcase
        end else begin
            case (addr_i)
                A_GSTAT: kind_o = RK_GSTAT;
                A_GACK:  kind_o = RK_GACK;
                A_GRAW:  kind_o = RK_GRAW;
                A_GVER:  kind_o = RK_GVER;
                default: kind_o = RK_NONE;
            endcase
        end
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_we_i,
    input  logic [CNT_W-1:0]  load_wdata_i,
    input  logic              ctrl_we_i,
    input  logic [CTRL_W-1:0] ctrl_wdata_i,
    input  logic              clr_i,
    output logic [CNT_W-1:0]  count_o,
    output logic [CNT_W-1:0]  load_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              raw_o,
    output logic              irq_o
);

    ch_state_e         state_q, state_d;
    logic [CNT_W-1:0]  count_q, count_d;
    logic [CNT_W-1:0]  load_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              raw_q, raw_d;
    logic              tc;
    logic              en, periodic, masked;

    assign en       = ctrl_q[BIT_EN];
    assign periodic = ctrl_q[BIT_PER];
    assign masked   = ctrl_q[BIT_MASK];

    // Software-visible configuration registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= '0;
            ctrl_q <= '0;
        end else begin
            if (load_we_i) load_q <= load_wdata_i;
            if (ctrl_we_i) ctrl_q <= ctrl_wdata_i;
        end
    end

    // State register process.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_HALT;
            count_q <= '0;
            raw_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            raw_q   <= raw_d;
        end
    end

    // Next-state and count engine: arm, wrap, stop.
    always_comb begin
        state_d = state_q;
        count_d = count_q;
        tc      = 1'b0;
        unique case (state_q)
            CH_HALT: begin
                if (en) begin
                    state_d = CH_RUN;
                    count_d = load_q;
                end
            end
            CH_RUN: begin
                if (!en) begin
                    state_d = CH_HALT;
                end else if (count_q == '0) begin
                    tc      = 1'b1;
                    count_d = periodic ? load_q : '1;
                end else begin
                    count_d = count_q - 1'b1;
                end
            end
            default: state_d = CH_HALT;
        endcase
        raw_d = tc | (raw_q & ~clr_i);
    end

    // Output process.
    always_comb begin
        count_o = count_q;
        load_o  = load_q;
        ctrl_o  = ctrl_q;
        raw_o   = raw_q;
        irq_o   = raw_q & ~masked;
    end

    p_arm_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_HALT && en) |=> (count_q == $past(load_q)));

    p_periodic_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_RUN && en && periodic && count_q == '0) |=> (count_q == $past(load_q) && raw_q));

    p_free_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_RUN && en && !periodic && count_q == '0) |=> (&count_q && raw_q));

    p_halt_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !$past(en)) |-> $stable(count_q));

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !tc) |=> !raw_q);

    p_event_beats_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && tc) |=> raw_q);

endmodule

// File: rtl/apb_tick_timer.sv
module apb_tick_timer
    import tmr_pkg::*;
#(
    parameter int unsigned NUM_CH     = 2,
    parameter int unsigned CNT_W      = 32,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned DATA_W     = 32,
    parameter logic [31:0] VERSION_ID = 32'h5449_0107
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    output logic [NUM_CH-1:0] tmr_irq,
    output logic              tmr_irq_any
);

    logic              access, wr_en, rd_en;
    logic [NUM_CH-1:0] ch_sel;
    reg_kind_e         kind;

    logic [CNT_W-1:0]  count_v [NUM_CH];
    logic [CNT_W-1:0]  load_v  [NUM_CH];
    logic [CTRL_W-1:0] ctrl_v  [NUM_CH];
    logic [NUM_CH-1:0] raw_v;
    logic [NUM_CH-1:0] clr_v;
    logic [NUM_CH-1:0] load_we_v;
    logic [NUM_CH-1:0] ctrl_we_v;

    assign access  = psel & penable;
    assign wr_en   = access & pwrite;
    assign rd_en   = access & ~pwrite;
    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    tmr_addr_decode #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_decode (
        .addr_i   (paddr),
        .ch_sel_o (ch_sel),
        .kind_o   (kind)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign load_we_v[g] = wr_en & ch_sel[g] & (kind == RK_LOAD);
        assign ctrl_we_v[g] = wr_en & ch_sel[g] & (kind == RK_CTRL);
        assign clr_v[g]     = rd_en & ((ch_sel[g] & (kind == RK_ACK)) | (kind == RK_GACK));

        tmr_channel #(
            .CNT_W (CNT_W)
        ) u_ch (
            .clk          (pclk),
            .rst_n        (presetn),
            .load_we_i    (load_we_v[g]),
            .load_wdata_i (pwdata[CNT_W-1:0]),
            .ctrl_we_i    (ctrl_we_v[g]),
            .ctrl_wdata_i (pwdata[CTRL_W-1:0]),
            .clr_i        (clr_v[g]),
            .count_o      (count_v[g]),
            .load_o       (load_v[g]),
            .ctrl_o       (ctrl_v[g]),
            .raw_o        (raw_v[g]),
            .irq_o        (tmr_irq[g])
        );
    end

    assign tmr_irq_any = |tmr_irq;

    always_comb begin
        prdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_sel[i]) begin
                unique case (kind)
                    RK_LOAD: prdata = DATA_W'(load_v[i]);
                    RK_CUR:  prdata = DATA_W'(count_v[i]);
                    RK_CTRL: prdata = DATA_W'(ctrl_v[i]);
                    RK_STAT: prdata = DATA_W'(tmr_irq[i]);
                    default: prdata = '0;
                endcase
            end
        end
        unique case (kind)
            RK_GSTAT: prdata = DATA_W'(tmr_irq);
            RK_GRAW:  prdata = DATA_W'(raw_v);
            RK_GVER:  prdata = DATA_W'(VERSION_ID);
            default:  ;
        endcase
    end

    p_unmapped_zero_r11: assert property (@(posedge pclk) disable iff (!presetn)
        (rd_en && kind == RK_NONE) |-> (prdata == '0));

    p_global_ack_r8: assert property (@(posedge pclk) disable iff (!presetn)
        (rd_en && kind == RK_GACK) |-> (clr_v == {NUM_CH{1'b1}}));

    p_mask_quiet_r6: assert property (@(posedge pclk) disable iff (!presetn)
        (raw_v == '0) |-> !tmr_irq_any);

endmodule

// File: tb/apb_tick_timer_tb_top.sv
`timescale 1ns/1ps
module apb_tick_timer_tb_top;

    localparam int NUM_CH = 2;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam logic [31:0] VER = 32'h5449_0107;
    localparam int STRIDE = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [ADDR_W-1:0] paddr = '0;
    logic [DATA_W-1:0] pwdata = '0;
    logic [DATA_W-1:0] prdata;
    logic              pready, pslverr;
    logic [NUM_CH-1:0] tmr_irq;
    logic              tmr_irq_any;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    apb_tick_timer #(.NUM_CH(NUM_CH), .VERSION_ID(VER)) dut_i (
        .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .tmr_irq(tmr_irq), .tmr_irq_any(tmr_irq_any)
    );

    // Behavioural reference model.
    logic [31:0] m_load [NUM_CH];
    logic [2:0]  m_ctrl [NUM_CH];
    logic [31:0] m_cnt  [NUM_CH];
    bit          m_run  [NUM_CH];
    bit          m_raw  [NUM_CH];

    always @(posedge clk) begin
        int a;
        bit rd, wr;
        a  = int'(paddr);
        rd = psel && penable && !pwrite;
        wr = psel && penable && pwrite;
        if (!rst_n) begin
            for (int i = 0; i < NUM_CH; i++) begin
                m_load[i] = 0; m_ctrl[i] = 0; m_cnt[i] = 0; m_run[i] = 0; m_raw[i] = 0;
            end
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                bit ev, ack;
                ev = 0;
                if (m_run[i]) begin
                    if (!m_ctrl[i][0]) m_run[i] = 0;
                    else if (m_cnt[i] == 0) begin
                        ev = 1;
                        m_cnt[i] = m_ctrl[i][1] ? m_load[i] : 32'hFFFF_FFFF;
                    end else m_cnt[i] = m_cnt[i] - 1;
                end else if (m_ctrl[i][0]) begin
                    m_cnt[i] = m_load[i];
                    m_run[i] = 1;
                end
                ack = rd && ((a == 'hA4) || (a == i*STRIDE + 'h0C));
                m_raw[i] = ev || (m_raw[i] && !ack);
            end
            if (wr && a < NUM_CH*STRIDE) begin
                if (a % STRIDE == 0) m_load[a/STRIDE] = pwdata;
                if (a % STRIDE == 8) m_ctrl[a/STRIDE] = pwdata[2:0];
            end
        end
    end

    function automatic logic [31:0] m_irq_vec();
        logic [31:0] v = 0;
        for (int i = 0; i < NUM_CH; i++) v[i] = m_raw[i] && !m_ctrl[i][2];
        return v;
    endfunction

    function automatic logic [31:0] m_read(int a);
        logic [31:0] v = 0;
        logic [31:0] iv = m_irq_vec();
        if (a < NUM_CH*STRIDE) begin
            case (a % STRIDE)
                0:  return m_load[a/STRIDE];
                4:  return m_cnt[a/STRIDE];
                8:  return {29'd0, m_ctrl[a/STRIDE]};
                16: return {31'd0, iv[a/STRIDE]};
                default: return 0;
            endcase
        end
        if (a == 'hA0) return iv;
        if (a == 'hA8) begin
            for (int i = 0; i < NUM_CH; i++) v[i] = m_raw[i];
            return v;
        end
        if (a == 'hAC) return VER;
        return 0;
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle interrupt comparison (R6, R12).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [31:0] e;
            e = m_irq_vec();
            chk(tmr_irq == e[NUM_CH-1:0], "R6/R12 irq vector", 32'(tmr_irq), e);
            chk(tmr_irq_any == (|e), "R12 irq_any", 32'(tmr_irq_any), 32'(|e));
        end
    end

    task automatic apb_write(int a, logic [31:0] d);
        @(negedge clk);
        psel = 1; pwrite = 1; penable = 0; paddr = ADDR_W'(a); pwdata = d;
        @(negedge clk);
        penable = 1;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_read(int a, string tag, output logic [31:0] got);
        logic [31:0] e;
        @(negedge clk);
        psel = 1; pwrite = 0; penable = 0; paddr = ADDR_W'(a);
        @(negedge clk);
        penable = 1;
        #1;
        got = prdata;
        e = m_read(a);
        chk(got == e, tag, got, e);
        chk(pready === 1'b1 && pslverr === 1'b0, "R11 pready/pslverr", {30'd0, pready, pslverr}, 32'h2);
        @(negedge clk);
        psel = 0; penable = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] r, r2;
        bit seen;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset values
        chk(tmr_irq == 0 && !tmr_irq_any, "R1 irq after reset", 32'(tmr_irq), 0);
        foreach (m_load[i]) begin
            apb_read(i*STRIDE + 'h00, "R1 load reset", r);
            chk(r == 0, "R1 load zero", r, 0);
            apb_read(i*STRIDE + 'h04, "R1 count reset", r);
            apb_read(i*STRIDE + 'h08, "R1 ctrl reset", r);
            apb_read(i*STRIDE + 'h10, "R1 status reset", r);
        end
        apb_read('hA0, "R1 gstat reset", r);
        apb_read('hA8, "R1 graw reset", r);

        // R2: enable edge loads, then falls
        apb_write('h00, 40);
        apb_write('h08, 3'b011);
        apb_read('h00, "R2 load readback", r);
        apb_read('h04, "R2 live count", r);
        apb_read('h04, "R2 live count later", r2);
        chk(r - r2 == 3, "R2 falls one per cycle", r - r2, 3);

        // R3: periodic wrap raises interrupt
        seen = 0;
        for (int k = 0; k < 100 && !seen; k++) begin
            @(negedge clk);
            if (tmr_irq[0]) seen = 1;
        end
        chk(seen, "R3 periodic event", 32'(seen), 1);
        apb_read('h04, "R3 reload value", r);
        apb_read('h10, "R3 masked status", r);

        // R4: free-running channel 1 wraps to all ones
        apb_write(STRIDE + 'h00, 6);
        apb_write(STRIDE + 'h08, 3'b001);
        idle(10);
        apb_read(STRIDE + 'h04, "R4 free-run wrap", r);
        chk(r > 32'hFFFF_FF00, "R4 near all ones", r, 32'hFFFF_FFF0);

        // R7: per-channel acknowledge
        apb_read('h0C, "R7 ack reads zero", r);
        chk(r == 0, "R7 ack value", r, 0);
        chk(tmr_irq[1] == 1'b1, "R7 other channel untouched", 32'(tmr_irq[1]), 1);
        apb_read('hA8, "R7 raw after ack", r);

        // R8: global acknowledge
        apb_read('hA4, "R8 gack reads zero", r);
        apb_read('hA8, "R8 raw after gack", r);

        // R5: disable holds count
        apb_write(STRIDE + 'h08, 3'b000);
        apb_read(STRIDE + 'h04, "R5 halted", r);
        idle(7);
        apb_read(STRIDE + 'h04, "R5 halted later", r2);
        chk(r == r2, "R5 count frozen", r2, r);

        // R2: new reload value takes effect on enable edge
        apb_write(STRIDE + 'h00, 2);
        apb_write(STRIDE + 'h08, 3'b111);
        apb_read(STRIDE + 'h04, "R2 reload after re-enable", r);

        // R6: masked channel
        idle(10);
        apb_read('hA8, "R6 raw with mask", r);
        chk(r[1] == 1'b1, "R6 raw set while masked", r, 32'h2);
        apb_read('hA0, "R6 masked status", r);
        chk(r[1] == 1'b0, "R6 gstat bit clear", r, 0);
        chk(tmr_irq[1] == 1'b0, "R6 irq low", 32'(tmr_irq[1]), 0);
        apb_read(STRIDE + 'h10, "R6 channel status", r);

        // R9: terminal event coincides with ack read
        apb_read('hA4, "R9 pre-clear", r);
        @(negedge clk);
        while (!(m_run[0] && m_ctrl[0][0] && m_cnt[0] == 2)) @(negedge clk);
        apb_read('h0C, "R9 ack at wrap", r);
        chk(tmr_irq[0] == 1'b1, "R9 event wins", 32'(tmr_irq[0]), 1);

        // R10: identification and shared status
        apb_read('hAC, "R10 version", r);
        chk(r == VER, "R10 version value", r, VER);
        apb_read('hA0, "R10 gstat", r);

        // R11: unmapped and read-only
        apb_write('h50, 32'hDEAD_BEEF);
        apb_read('h50, "R11 unmapped read", r);
        chk(r == 0, "R11 unmapped zero", r, 0);
        apb_read('hB0, "R11 unmapped high", r);
        apb_write('h04, 5);
        apb_read('h04, "R11 count not writable", r);
        apb_read('h14 + 'h0C + 4, "R11 channel status slot", r);

        idle(20);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule